// File: doc/BRIEF.md
# ID-Checked RTS/CTS Access Controller

This block is the medium-access state machine of one node on a shared spread-spectrum ad hoc link. It acts as a sender and as a receiver at the same time. Frames are abstracted as single-cycle typed strobes that carry an ID field and a payload word. Spreading and modulation belong to other blocks.

As a sender, the node takes a transfer request from its host and emits a request-to-send that names the destination. It waits for a clear-to-send from that destination, then sends the data frame and waits for an acknowledgement. Each wait is bounded by a programmable timeout. As a receiver, it compares the destination field of every incoming request-to-send with the node's own ID. On a match it grants at once. On a mismatch it pulses a reduce-power indication toward the offending transmitter. This keeps a nearby sender that is not addressed from swamping a weaker intended one.

Both roles share one outgoing frame slot, which is registered. Frame kind encoding on `in_kind` and `out_kind`: 0 request-to-send, 1 clear-to-send, 2 data, 3 acknowledgement.

Top module: `idmac_ctrl`

## Requirements
- R1: When idle, a `tx_req` pulse latches `tx_dst` and `tx_data`, raises `tx_busy` and emits a request-to-send (kind 0) with `out_id` equal to the latched destination and zero payload. The frame appears in the first free output slot after the request cycle. A `tx_req` while busy is ignored.
- R2: An incoming request-to-send whose ID equals `cfg_self_id` is answered on the very next cycle with a clear-to-send (kind 1), carrying `out_id = cfg_self_id` and zero payload. The receiver then enters its granted state.
- R3: The sender emits its data frame (kind 2, `out_id` = destination, `out_data` = latched word) only after a clear-to-send whose ID equals the destination arrived while it was waiting. A clear-to-send with any other ID is ignored.
- R4: In the granted state, a data frame whose ID equals `cfg_self_id` produces, on the next cycle, a one-cycle `rx_valid` with `rx_data` equal to the payload. On the same cycle it produces an acknowledgement (kind 3, `out_id = cfg_self_id`, zero payload). The receiver then returns to idle.
- R5: While waiting for an acknowledgement, an acknowledgement whose ID equals the destination gives a one-cycle `tx_done` on the next cycle, and the sender returns to idle.
- R6: A request-to-send whose ID differs from `cfg_self_id` gives a one-cycle `pwr_reduce` on the next cycle. This happens in any state, and no grant follows.
- R7: If a wait for clear-to-send or for acknowledgement lasts `cfg_timeout` cycles with no matching reply, `tx_fail` pulses once and the sender returns to idle. A matching reply on the last cycle still wins. A value of 0 disables the timeout.
- R8: Out-of-order frames leave every state unchanged. These are data without a grant, clear-to-send or acknowledgement outside the matching wait, and a matching request-to-send while already granted.
- R9: When a receiver reply and a sender frame fall in the same cycle, the reply takes the slot and the sender frame follows one cycle later.
- R10: A grant that sees no matching data for `cfg_timeout` cycles (0: never) lapses. Data arriving after that is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_self_id | input | ID_W | This node's own ID |
| cfg_timeout | input | TMO_W | Wait limit in cycles, 0 disables |
| tx_req | input | 1 | Host request to start a transfer |
| tx_dst | input | ID_W | Destination ID of the transfer |
| tx_data | input | DATA_W | Payload word of the transfer |
| tx_busy | output | 1 | Sender is not idle |
| tx_done | output | 1 | Transfer acknowledged |
| tx_fail | output | 1 | Transfer abandoned on timeout |
| in_valid | input | 1 | Incoming frame strobe |
| in_kind | input | 2 | Incoming frame kind |
| in_id | input | ID_W | Incoming frame ID field |
| in_data | input | DATA_W | Incoming frame payload |
| out_valid | output | 1 | Outgoing frame strobe |
| out_kind | output | 2 | Outgoing frame kind |
| out_id | output | ID_W | Outgoing frame ID field |
| out_data | output | DATA_W | Outgoing frame payload |
| rx_valid | output | 1 | Accepted payload strobe |
| rx_data | output | DATA_W | Accepted payload word |
| pwr_reduce | output | 1 | Reduce-power indication to the transmitter |

## Verification
A behavioural model of both roles predicts every output on every cycle. It is driven first by directed handshakes and then by thousands of cycles of random frames, with IDs biased toward the node's own ID and the current destination.

- The directed patterns cover a clean sender exchange and a clean receiver exchange. They also cover wrong-ID replies, lapsed waits with and without a timeout, and a request arriving in the same cycle the sender wants the slot. Together these separate the correct ID checks, the timing of expiry and the reply priority from near-miss variants.
- The random phase catches out-of-order frames that fall at any point in either state machine.

// File: rtl/idmac_pkg.sv
`timescale 1ns/1ps
package idmac_pkg;

    // frame kind codes on the link; values are fixed by the frame format
    typedef enum logic [1:0] {
        FK_RTS  = 2'd0,
        FK_CTS  = 2'd1,
        FK_DATA = 2'd2,
        FK_ACK  = 2'd3
    } frame_kind_e;

    typedef enum logic [2:0] {
        SND_IDLE = 3'd0,
        SND_RTS  = 3'd1,
        SND_WCTS = 3'd2,
        SND_DATA = 3'd3,
        SND_WACK = 3'd4
    } snd_state_e;

    typedef enum logic {
        RCV_IDLE  = 1'b0,
        RCV_GRANT = 1'b1
    } rcv_state_e;

endpackage

// File: rtl/idmac_timer.sv
`timescale 1ns/1ps
module idmac_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t tmr_d, tmr_q;

    // counter restarts whenever the owner leaves its waiting state
    always_comb begin
        tmr_d     = tmr_q;
        tmr_d.cnt = run ? (tmr_q.cnt + ONE) : '0;
    end

    assign expire = run && (limit != '0) && (tmr_q.cnt == (limit - ONE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/idmac_sender.sv
`timescale 1ns/1ps
module idmac_sender
    import idmac_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int DATA_W = 8,
    parameter int TMO_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ID_W-1:0]   req_dst,
    input  logic [DATA_W-1:0] req_data,
    input  logic              in_valid,
    input  frame_kind_e       in_kind,
    input  logic [ID_W-1:0]   in_id,
    input  logic              slot_taken,
    input  logic [TMO_W-1:0]  limit,
    output logic              want,
    output frame_kind_e       want_kind,
    output logic [ID_W-1:0]   want_id,
    output logic [DATA_W-1:0] want_data,
    output logic              busy,
    output logic              done,
    output logic              fail
);

    typedef struct packed {
        snd_state_e        st;
        logic [ID_W-1:0]   dst;
        logic [DATA_W-1:0] dat;
        logic              done;
        logic              fail;
    } snd_regs_t;

    snd_regs_t snd_d, snd_q;

    logic waiting;
    logic wait_expired;
    logic cts_hit;
    logic ack_hit;

    assign waiting = (snd_q.st == SND_WCTS) || (snd_q.st == SND_WACK);
    assign cts_hit = in_valid && (in_kind == FK_CTS) && (in_id == snd_q.dst);
    assign ack_hit = in_valid && (in_kind == FK_ACK) && (in_id == snd_q.dst);

    idmac_timer #(
        .CNT_W(TMO_W)
    ) u_wait_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (waiting),
        .limit  (limit),
        .expire (wait_expired)
    );

    always_comb begin
        snd_d      = snd_q;
        snd_d.done = 1'b0;
        snd_d.fail = 1'b0;
        unique case (snd_q.st)
            SND_IDLE: begin
                if (req) begin
                    snd_d.dst = req_dst;
                    snd_d.dat = req_data;
                    snd_d.st  = SND_RTS;
                end
            end
            SND_RTS: begin
                if (!slot_taken) begin
                    snd_d.st = SND_WCTS;
                end
            end
            SND_WCTS: begin
                if (cts_hit) begin
                    snd_d.st = SND_DATA;
                end else if (wait_expired) begin
                    snd_d.fail = 1'b1;
                    snd_d.st   = SND_IDLE;
                end
            end
            SND_DATA: begin
                if (!slot_taken) begin
                    snd_d.st = SND_WACK;
                end
            end
            SND_WACK: begin
                if (ack_hit) begin
                    snd_d.done = 1'b1;
                    snd_d.st   = SND_IDLE;
                end else if (wait_expired) begin
                    snd_d.fail = 1'b1;
                    snd_d.st   = SND_IDLE;
                end
            end
            default: begin
                snd_d.st = SND_IDLE;
            end
        endcase
    end

    always_comb begin
        want      = (snd_q.st == SND_RTS) || (snd_q.st == SND_DATA);
        want_kind = (snd_q.st == SND_DATA) ? FK_DATA : FK_RTS;
        want_id   = snd_q.dst;
        want_data = (snd_q.st == SND_DATA) ? snd_q.dat : '0;
    end

    assign busy = (snd_q.st != SND_IDLE);
    assign done = snd_q.done;
    assign fail = snd_q.fail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snd_q    <= '0;
            snd_q.st <= SND_IDLE;
        end else begin
            snd_q <= snd_d;
        end
    end

    AST_DATA_AFTER_CTS: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_q.st == SND_DATA) && ($past(snd_q.st) == SND_WCTS)
        |-> $past(in_valid && (in_kind == FK_CTS))); // R3

    AST_FAIL_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        snd_q.fail |-> $past((snd_q.st == SND_WCTS) || (snd_q.st == SND_WACK))); // R7

    AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(snd_q.done && snd_q.fail)); // R7

endmodule

// File: rtl/idmac_receiver.sv
`timescale 1ns/1ps
module idmac_receiver
    import idmac_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int DATA_W = 8,
    parameter int TMO_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   self_id,
    input  logic [TMO_W-1:0]  limit,
    input  logic              in_valid,
    input  frame_kind_e       in_kind,
    input  logic [ID_W-1:0]   in_id,
    input  logic [DATA_W-1:0] in_data,
    output logic              resp_valid,
    output frame_kind_e       resp_kind,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              pwr_reduce
);

    typedef struct packed {
        rcv_state_e        st;
        logic              rx_valid;
        logic [DATA_W-1:0] rx_data;
        logic              pwr;
    } rcv_regs_t;

    rcv_regs_t rcv_d, rcv_q;

    logic granted;
    logic grant_lapsed;
    logic id_match;
    logic rts_seen;
    logic rts_grant;
    logic data_take;

    assign granted   = (rcv_q.st == RCV_GRANT);
    assign id_match  = (in_id == self_id);
    assign rts_seen  = in_valid && (in_kind == FK_RTS);
    assign rts_grant = rts_seen && id_match && !granted;
    assign data_take = in_valid && (in_kind == FK_DATA) && id_match && granted;

    idmac_timer #(
        .CNT_W(TMO_W)
    ) u_grant_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (granted),
        .limit  (limit),
        .expire (grant_lapsed)
    );

    always_comb begin
        rcv_d          = rcv_q;
        rcv_d.rx_valid = 1'b0;
        rcv_d.pwr      = rts_seen && !id_match;
        if (rts_grant) begin
            rcv_d.st = RCV_GRANT;
        end else if (data_take) begin
            rcv_d.rx_valid = 1'b1;
            rcv_d.rx_data  = in_data;
            rcv_d.st       = RCV_IDLE;
        end else if (grant_lapsed) begin
            rcv_d.st = RCV_IDLE;
        end
    end

    // replies leave with the next register stage in the top
    assign resp_valid = rts_grant || data_take;
    assign resp_kind  = data_take ? FK_ACK : FK_CTS;

    assign rx_valid   = rcv_q.rx_valid;
    assign rx_data    = rcv_q.rx_data;
    assign pwr_reduce = rcv_q.pwr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcv_q    <= '0;
            rcv_q.st <= RCV_IDLE;
        end else begin
            rcv_q <= rcv_d;
        end
    end

    AST_RX_ONLY_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_q.rx_valid |-> $past(rcv_q.st == RCV_GRANT)); // R4

    AST_GRANT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_q.st == RCV_GRANT) && ($past(rcv_q.st) == RCV_IDLE)
        |-> $past(in_valid && (in_kind == FK_RTS) && (in_id == self_id))); // R2

endmodule

// File: rtl/idmac_ctrl.sv
`timescale 1ns/1ps
module idmac_ctrl
    import idmac_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int DATA_W = 8,
    parameter int TMO_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   cfg_self_id,
    input  logic [TMO_W-1:0]  cfg_timeout,
    input  logic              tx_req,
    input  logic [ID_W-1:0]   tx_dst,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_busy,
    output logic              tx_done,
    output logic              tx_fail,
    input  logic              in_valid,
    input  logic [1:0]        in_kind,
    input  logic [ID_W-1:0]   in_id,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [1:0]        out_kind,
    output logic [ID_W-1:0]   out_id,
    output logic [DATA_W-1:0] out_data,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              pwr_reduce
);

    typedef struct packed {
        logic              valid;
        frame_kind_e       kind;
        logic [ID_W-1:0]   id;
        logic [DATA_W-1:0] data;
    } out_regs_t;

    out_regs_t out_d, out_q;

    frame_kind_e       in_kind_e;
    logic              resp_valid;
    frame_kind_e       resp_kind;
    logic              snd_want;
    frame_kind_e       snd_kind;
    logic [ID_W-1:0]   snd_id;
    logic [DATA_W-1:0] snd_data;

    assign in_kind_e = frame_kind_e'(in_kind);

    idmac_receiver #(
        .ID_W   (ID_W),
        .DATA_W (DATA_W),
        .TMO_W  (TMO_W)
    ) u_rcv (
        .clk        (clk),
        .rst_n      (rst_n),
        .self_id    (cfg_self_id),
        .limit      (cfg_timeout),
        .in_valid   (in_valid),
        .in_kind    (in_kind_e),
        .in_id      (in_id),
        .in_data    (in_data),
        .resp_valid (resp_valid),
        .resp_kind  (resp_kind),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .pwr_reduce (pwr_reduce)
    );

    idmac_sender #(
        .ID_W   (ID_W),
        .DATA_W (DATA_W),
        .TMO_W  (TMO_W)
    ) u_snd (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (tx_req),
        .req_dst    (tx_dst),
        .req_data   (tx_data),
        .in_valid   (in_valid),
        .in_kind    (in_kind_e),
        .in_id      (in_id),
        .slot_taken (resp_valid),
        .limit      (cfg_timeout),
        .want       (snd_want),
        .want_kind  (snd_kind),
        .want_id    (snd_id),
        .want_data  (snd_data),
        .busy       (tx_busy),
        .done       (tx_done),
        .fail       (tx_fail)
    );

    // single outgoing slot: receiver replies first, sender frames wait
    always_comb begin
        out_d       = '0;
        out_d.kind  = FK_RTS;
        if (resp_valid) begin
            out_d.valid = 1'b1;
            out_d.kind  = resp_kind;
            out_d.id    = cfg_self_id;
        end else if (snd_want) begin
            out_d.valid = 1'b1;
            out_d.kind  = snd_kind;
            out_d.id    = snd_id;
            out_d.data  = snd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q      <= '0;
            out_q.kind <= FK_RTS;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.valid;
    assign out_kind  = out_q.kind;
    assign out_id    = out_q.id;
    assign out_data  = out_q.data;

    AST_CTS_ANSWERS_RTS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_kind == FK_CTS)
        |-> $past(in_valid && (in_kind == FK_RTS) && (in_id == cfg_self_id))); // R2

    AST_PWR_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_reduce |-> !(out_valid && (out_kind == FK_CTS))); // R6

    AST_DONE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> $past(in_valid && (in_kind == FK_ACK))); // R5

    AST_ACK_WITH_RX: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (out_valid && (out_kind == FK_ACK))); // R4

endmodule

// File: tb/idmac_ctrl_bench.sv
`timescale 1ns/1ps
module idmac_ctrl_bench;

    localparam int ID_W   = 4;
    localparam int DATA_W = 8;
    localparam int TMO_W  = 8;
    localparam int SELF   = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ID_W-1:0]   cfg_self_id;
    logic [TMO_W-1:0]  cfg_timeout;
    logic              tx_req;
    logic [ID_W-1:0]   tx_dst;
    logic [DATA_W-1:0] tx_data;
    logic              tx_busy, tx_done, tx_fail;
    logic              in_valid;
    logic [1:0]        in_kind;
    logic [ID_W-1:0]   in_id;
    logic [DATA_W-1:0] in_data;
    logic              out_valid;
    logic [1:0]        out_kind;
    logic [ID_W-1:0]   out_id;
    logic [DATA_W-1:0] out_data;
    logic              rx_valid;
    logic [DATA_W-1:0] rx_data;
    logic              pwr_reduce;

    always #2.5 clk = ~clk;

    idmac_ctrl #(
        .ID_W(ID_W), .DATA_W(DATA_W), .TMO_W(TMO_W)
    ) u_idmac_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_self_id(cfg_self_id), .cfg_timeout(cfg_timeout),
        .tx_req(tx_req), .tx_dst(tx_dst), .tx_data(tx_data),
        .tx_busy(tx_busy), .tx_done(tx_done), .tx_fail(tx_fail),
        .in_valid(in_valid), .in_kind(in_kind), .in_id(in_id), .in_data(in_data),
        .out_valid(out_valid), .out_kind(out_kind), .out_id(out_id), .out_data(out_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .pwr_reduce(pwr_reduce)
    );

    int checks = 0;
    int errors = 0;
    int n_done = 0, n_fail = 0, n_pwr = 0, n_rxv = 0;
    bit finished = 0;

    // reference model state (sender 0 idle,1 rts,2 wait cts,3 data,4 wait ack)
    int m_sst = 0, m_scnt = 0, m_sdst = 0, m_sdat = 0, m_snext = 0;
    int m_rst = 0, m_rcnt = 0, m_rnext = 0;
    int m_resp = 0, m_rk = 0, m_sov = 0, m_sk = 0, m_sid = 0, m_sdout = 0;
    int m_exp = 0, m_tmo = 0;
    int e_ov = 0, e_ok = 0, e_oid = 0, e_od = 0;
    int e_done = 0, e_fail = 0, e_pwr = 0, e_rxv = 0, e_rxd = 0, e_busy = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sst = 0; m_scnt = 0; m_rst = 0; m_rcnt = 0; m_sdst = 0; m_sdat = 0;
            e_ov = 0; e_done = 0; e_fail = 0; e_pwr = 0; e_rxv = 0; e_busy = 0;
        end else begin
            m_tmo = int'(cfg_timeout);
            // receiver role
            m_resp = 0; m_rk = 0; e_pwr = 0; e_rxv = 0; m_rnext = m_rst;
            if (in_valid && in_kind == 2'd0 && int'(in_id) != SELF) e_pwr = 1;
            if (in_valid && in_kind == 2'd0 && int'(in_id) == SELF && m_rst == 0) begin
                m_resp = 1; m_rk = 1; m_rnext = 1;
            end else if (in_valid && in_kind == 2'd2 && int'(in_id) == SELF && m_rst == 1) begin
                m_resp = 1; m_rk = 3; m_rnext = 0; e_rxv = 1; e_rxd = int'(in_data);
            end else if (m_rst == 1 && m_tmo != 0 && m_rcnt == m_tmo - 1) begin
                m_rnext = 0;
            end
            m_rcnt = (m_rst == 1) ? (m_rcnt + 1) % 256 : 0;
            m_rst  = m_rnext;
            // sender role
            m_sov = 0; e_done = 0; e_fail = 0; m_snext = m_sst;
            m_exp = (m_tmo != 0 && m_scnt == m_tmo - 1) ? 1 : 0;
            case (m_sst)
                0: if (tx_req) begin
                       m_sdst = int'(tx_dst); m_sdat = int'(tx_data); m_snext = 1;
                   end
                1: if (!m_resp) begin m_sov = 1; m_sk = 0; m_sdout = 0; m_snext = 2; end
                2: if (in_valid && in_kind == 2'd1 && int'(in_id) == m_sdst) m_snext = 3;
                   else if (m_exp) begin e_fail = 1; m_snext = 0; end
                3: if (!m_resp) begin m_sov = 1; m_sk = 2; m_sdout = m_sdat; m_snext = 4; end
                default: if (in_valid && in_kind == 2'd3 && int'(in_id) == m_sdst) begin
                       e_done = 1; m_snext = 0;
                   end else if (m_exp) begin e_fail = 1; m_snext = 0; end
            endcase
            m_sid  = m_sdst;
            m_scnt = (m_sst == 2 || m_sst == 4) ? (m_scnt + 1) % 256 : 0;
            m_sst  = m_snext;
            e_busy = (m_sst != 0) ? 1 : 0;
            // shared slot
            if (m_resp) begin
                e_ov = 1; e_ok = m_rk; e_oid = SELF; e_od = 0;
            end else if (m_sov) begin
                e_ov = 1; e_ok = m_sk; e_oid = m_sid; e_od = m_sdout;
            end else begin
                e_ov = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1 R8 tx_busy", int'(tx_busy), e_busy);
            chk("R9 out_valid", int'(out_valid), e_ov);
            if (out_valid && e_ov != 0) begin
                case (e_ok)
                    0: chk("R1 out_kind", int'(out_kind), e_ok);
                    1: chk("R2 out_kind", int'(out_kind), e_ok);
                    2: chk("R3 out_kind", int'(out_kind), e_ok);
                    default: chk("R4 R5 out_kind", int'(out_kind), e_ok);
                endcase
                chk("R9 out_id", int'(out_id), e_oid);
                chk("R3 out_data", int'(out_data), e_od);
            end
            chk("R5 tx_done", int'(tx_done), e_done);
            chk("R7 tx_fail", int'(tx_fail), e_fail);
            chk("R6 pwr_reduce", int'(pwr_reduce), e_pwr);
            chk("R4 R10 rx_valid", int'(rx_valid), e_rxv);
            if (rx_valid && e_rxv != 0) chk("R4 rx_data", int'(rx_data), e_rxd);
            if (tx_done) n_done++;
            if (tx_fail) n_fail++;
            if (pwr_reduce) n_pwr++;
            if (rx_valid) n_rxv++;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input int kind, input int id, input int data);
        in_valid = 1'b1;
        in_kind  = 2'(kind);
        in_id    = ID_W'(id);
        in_data  = DATA_W'(data);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic request(input int dst, input int data);
        tx_req  = 1'b1;
        tx_dst  = ID_W'(dst);
        tx_data = DATA_W'(data);
        @(negedge clk);
        tx_req = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        finish_run();
    end

    initial begin
        cfg_self_id = ID_W'(SELF);
        cfg_timeout = 8'd6;
        tx_req = 0; tx_dst = '0; tx_data = '0;
        in_valid = 0; in_kind = '0; in_id = '0; in_data = '0;
        idle(3);
        // reset state
        chk("R1 reset out_valid", int'(out_valid), 0);
        chk("R1 reset tx_busy", int'(tx_busy), 0);
        chk("R4 reset rx_valid", int'(rx_valid), 0);
        chk("R6 reset pwr_reduce", int'(pwr_reduce), 0);
        rst_n = 1'b1;
        idle(2);

        // R1 R3 R5: clean sender exchange
        request(9, 8'hA5);
        idle(3);
        frame(1, 9, 0);
        idle(2);
        frame(3, 9, 0);
        idle(2);

        // R2 R4: clean receiver exchange
        frame(0, SELF, 0);
        idle(1);
        frame(2, SELF, 8'h3C);
        idle(2);

        // R6 then R8: mismatched request, then data without a grant
        frame(0, 7, 0);
        frame(2, SELF, 8'h11);
        frame(3, 9, 0);
        frame(1, 9, 0);
        idle(2);

        // R7: no clear-to-send arrives
        request(12, 8'h44);
        idle(10);

        // R3 R8 R7: wrong-ID clear-to-send, then right one, then ack lapses
        request(3, 8'h77);
        idle(2);
        frame(1, 4, 0);
        request(6, 8'h99);
        frame(1, 3, 0);
        idle(10);

        // R9: request in the cycle the sender wants the slot
        request(10, 8'h5A);
        frame(0, SELF, 0);
        frame(0, SELF, 0);
        frame(2, SELF, 8'hE1);
        frame(1, 10, 0);
        idle(1);
        frame(3, 10, 0);
        idle(2);

        // R10: grant lapses, late data ignored
        frame(0, SELF, 0);
        idle(8);
        frame(2, SELF, 8'h22);
        idle(2);

        // R7: timeout disabled
        cfg_timeout = 8'd0;
        request(11, 8'h13);
        idle(20);
        frame(1, 11, 0);
        idle(3);
        frame(3, 11, 0);
        idle(2);

        // random frames against the model
        cfg_timeout = 8'd12;
        for (int i = 0; i < 4000; i++) begin
            tx_req   = ($urandom_range(0, 7) == 0);
            tx_dst   = ID_W'($urandom_range(6, 9));
            tx_data  = DATA_W'($urandom);
            in_valid = ($urandom_range(0, 2) == 0);
            in_kind  = 2'($urandom_range(0, 3));
            case ($urandom_range(0, 2))
                0: in_id = ID_W'(SELF);
                1: in_id = ID_W'($urandom_range(6, 9));
                default: in_id = ID_W'($urandom_range(0, 15));
            endcase
            in_data = DATA_W'($urandom);
            if (i == 2000) cfg_timeout = 8'd3;
            @(negedge clk);
        end
        tx_req = 0; in_valid = 0;
        idle(20);

        chk("R5 done seen", int'(n_done > 0), 1);
        chk("R7 fail seen", int'(n_fail > 0), 1);
        chk("R6 reduce seen", int'(n_pwr > 0), 1);
        chk("R4 payload seen", int'(n_rxv > 0), 1);
        finish_run();
    end

endmodule